// File: doc/BRIEF.md
# FIFO Counter Self-Test Engine with Three-Section Signature

This block is a built-in self-test engine for a small embedded RAM that can also run as a FIFO. A tester loads an 8-bit control word over a serial port and picks one of four counter tests. It can also carry pointers across depth changes, which stands in for a cascaded neighbour. A strobe on the update input then starts the run. The engine drives the RAM's write and read ports itself. For every supported depth, from the full array down by halves, it walks the write and read pointers through a complete sequence. The full and empty flags gate each access.

During the run, the responses feed three 16-bit CRC registers. One compresses the write-side pointer and flag activity, one compresses the read-pointer activity, and one compresses the data returned by the RAM. While the engine is busy the signature cannot be read. Once busy drops, the tester clocks the 48 signature bits out serially and compares them with a value computed ahead of time. The RAM array itself sits outside the block and returns read data one cycle after a read strobe.

Top module: `fifo_bist`

## Requirements
- R1: After reset, busy is low, no RAM write or read is issued, and all 48 signature bits read back as zero.
- R2: The control word shifts in on `ctl_sdi` while `ctl_shift_en` is high, entering at bit 7 and moving toward bit 0, so the first bit sent lands in bit 0 after eight shifts. Bits [1:0] select the test, bit 2 is the start request, bit 3 is the cascade enable, and bits [7:4] have no effect.
- R3: A pulse on `ctl_update` while idle with start bit 1 raises busy on the next clock edge and resets all three CRCs to 0xFFFF. An update with start bit 0, or any update while busy, leaves busy, the run and the signature unchanged.
- R4: A run visits NCFG depth settings in order, with depth 2^AW, 2^(AW-1) and so on. Each setting lasts 2*depth steps and is followed by one flush cycle, so busy stays high for 2*(sum of depths)+1 cycles (121 with defaults). RAM addresses are the pointer value modulo the current depth.
- R5: Within a setting, at step s of 2*D: test 0 requests a write for s<D and a read otherwise; test 1 requests a write on even steps and a read on odd steps; test 2 requests a write on every step and a read on every step but the first; test 3 requests a read for s<D and a write otherwise.
- R6: A requested write is issued only while occupancy is below the current depth. A requested read is issued only while occupancy is nonzero. The flags are judged on the state before the step, and each issued access advances its pointer by one.
- R7: With cascade enable 0, both pointers and the occupancy clear when a new depth setting begins. With cascade enable 1, they carry over unchanged.
- R8: Write data is the write pointer zero-extended to DW bits, inverted bit-wise on odd depth-setting indices.
- R9: Each run step feeds the write section with {full, empty, write issued, write pointer} and the read section with {read issued, read pointer}. The data section takes the RAM read data on the cycle after each issued read, including during the flush cycle. Each word is folded in most significant bit first through a CRC with polynomial x^16+x^12+x^5+1.
- R10: With busy low, each cycle of `sig_shift_en` shifts the 48-bit chain {write CRC, read CRC, data CRC} one place toward bit 0, with `sig_sdo` showing bit 0. While busy, `sig_shift_en` has no effect, and without a shift or start request the signature holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_shift_en | input | 1 | Shift enable for the control word |
| ctl_sdi | input | 1 | Serial control data in |
| ctl_update | input | 1 | Applies the loaded control word |
| sig_shift_en | input | 1 | Shift enable for the signature chain |
| sig_sdo | output | 1 | Serial signature out (chain bit 0) |
| busy | output | 1 | High while a test runs |
| mem_we | output | 1 | RAM write strobe |
| mem_waddr | output | AW | RAM write address |
| mem_wdata | output | DW | RAM write data |
| mem_re | output | 1 | RAM read strobe |
| mem_raddr | output | AW | RAM read address |
| mem_rdata | input | DW | RAM read data, valid the cycle after mem_re |

## Verification
The properties assume the tester never shifts the control word and pulses update in the same cycle. They also assume a start request and a signature shift never arrive together, and that the RAM answers every read strobe with data one cycle later. The bench drives every control input on the falling edge and keeps these requests in separate cycles. Its RAM model registers read data on the rising edge, reading before writing, and its contents start at zero. The deliberate misuse it applies, an update and a shift request during a run, stays within the cases that R3 and R10 define.

// File: rtl/fbist_pkg.sv
`timescale 1ns/1ps
package fbist_pkg;
  localparam int CTL_W = 8;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLUSH} bist_st_t;
  typedef enum logic [1:0] {T_FILL_DRAIN, T_PINGPONG, T_STREAM, T_UNDERRUN} bist_test_t;

  // Fold the low n bits of d into the CRC, most significant first.
  function automatic logic [CRC_W-1:0] crc_feed(input logic [CRC_W-1:0] c,
                                                input logic [31:0] d, input int n);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (i < n) begin
        fb = r[CRC_W-1] ^ d[i];
        r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/fbist_ctl.sv
`timescale 1ns/1ps
module fbist_ctl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sdi,
  output logic [W-1:0] word
);
  logic [W-1:0] word_d;

  always_comb begin
    word_d = {sdi, word[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= word_d;
  end
endmodule

// File: rtl/fbist_seq.sv
`timescale 1ns/1ps
module fbist_seq import fbist_pkg::*; #(
  parameter int AW   = 5,
  parameter int DW   = 8,
  parameter int NCFG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    sel_in,
  input  logic          casc_in,
  output logic          busy,
  output logic          run,
  output logic          flush,
  output logic          we,
  output logic          re,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] wdata,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW:0]   occ,
  output logic [AW:0]   depth
);
  localparam int CW = (NCFG > 1) ? $clog2(NCFG) : 1;
  localparam int SW = AW + 1;
  localparam logic [AW:0] TOP_DEPTH = (AW+1)'(1) << AW;
  localparam logic [CW-1:0] LAST_CFG = CW'(NCFG - 1);

  bist_st_t    st_q, st_d;
  logic [CW-1:0] cfg_q, cfg_d;
  logic [SW-1:0] step_q, step_d;
  logic [AW-1:0] wp_d, rp_d, mask;
  logic [AW:0]   cnt_d;
  logic [1:0]    sel_q;
  logic          casc_q;
  logic          want_w, want_r, last_step, first_half, adv;
  logic [SW-1:0] two_d_m1;

  always_comb begin
    depth      = TOP_DEPTH >> cfg_q;
    mask       = depth[AW-1:0] - 1'b1;
    two_d_m1   = SW'({depth, 1'b0} - 1'b1);
    last_step  = (step_q == two_d_m1);
    first_half = (step_q < depth);
    full       = (occ >= depth);
    empty      = (occ == '0);
    run        = (st_q == ST_RUN);
    flush      = (st_q == ST_FLUSH);
    busy       = (st_q != ST_IDLE);
    case (bist_test_t'(sel_q))
      T_FILL_DRAIN: begin want_w = first_half;  want_r = !first_half; end
      T_PINGPONG:   begin want_w = !step_q[0];  want_r = step_q[0];   end
      T_STREAM:     begin want_w = 1'b1;        want_r = (step_q != '0); end
      default:      begin want_w = !first_half; want_r = first_half;  end
    endcase
    we    = run && want_w && !full;
    re    = run && want_r && !empty;
    waddr = wptr & mask;
    raddr = rptr & mask;
    wdata = cfg_q[0] ? ~DW'(wptr) : DW'(wptr);
  end

  always_comb begin
    st_d   = st_q;
    cfg_d  = cfg_q;
    step_d = step_q;
    wp_d   = wptr;
    rp_d   = rptr;
    cnt_d  = occ;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d = ST_RUN; cfg_d = '0; step_d = '0;
          wp_d = '0; rp_d = '0; cnt_d = '0;
        end
      end
      ST_RUN: begin
        wp_d   = wptr + AW'(we);
        rp_d   = rptr + AW'(re);
        cnt_d  = occ + (AW+1)'(we) - (AW+1)'(re);
        step_d = step_q + 1'b1;
        if (last_step) begin
          step_d = '0;
          if (cfg_q == LAST_CFG) begin
            st_d = ST_FLUSH;
          end else begin
            cfg_d = cfg_q + 1'b1;
            if (!casc_q) begin wp_d = '0; rp_d = '0; cnt_d = '0; end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign adv = busy || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cfg_q <= '0; step_q <= '0;
      wptr <= '0; rptr <= '0; occ <= '0;
      sel_q <= '0; casc_q <= 1'b0;
    end else if (adv) begin
      st_q <= st_d; cfg_q <= cfg_d; step_q <= step_d;
      wptr <= wp_d; rptr <= rp_d; occ <= cnt_d;
      if (start && !busy) begin
        sel_q  <= sel_in;
        casc_q <= casc_in;
      end
    end
  end
endmodule

// File: rtl/fbist_sig.sv
`timescale 1ns/1ps
module fbist_sig import fbist_pkg::*; #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               run,
  input  logic               flush,
  input  logic               shift,
  input  logic               full,
  input  logic               empty,
  input  logic               we,
  input  logic               re,
  input  logic [AW-1:0]      wptr,
  input  logic [AW-1:0]      rptr,
  input  logic [DW-1:0]      rdata,
  output logic               sdo,
  output logic [3*CRC_W-1:0] chain
);
  logic [CRC_W-1:0] wsec_q, rsec_q, dsec_q, wsec_d, rsec_d, dsec_d;
  logic             rv_q, rv_d, en;

  assign chain = {wsec_q, rsec_q, dsec_q};
  assign sdo   = dsec_q[0];
  assign en    = clear || run || flush || shift;

  always_comb begin
    wsec_d = wsec_q; rsec_d = rsec_q; dsec_d = dsec_q; rv_d = rv_q;
    if (clear) begin
      wsec_d = CRC_SEED; rsec_d = CRC_SEED; dsec_d = CRC_SEED; rv_d = 1'b0;
    end else if (run) begin
      wsec_d = crc_feed(wsec_q, 32'({full, empty, we, wptr}), AW + 3);
      rsec_d = crc_feed(rsec_q, 32'({re, rptr}), AW + 1);
      if (rv_q) dsec_d = crc_feed(dsec_q, 32'(rdata), DW);
      rv_d = re;
    end else if (flush) begin
      if (rv_q) dsec_d = crc_feed(dsec_q, 32'(rdata), DW);
      rv_d = 1'b0;
    end else if (shift) begin
      {wsec_d, rsec_d, dsec_d} = {1'b0, chain[3*CRC_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsec_q <= '0; rsec_q <= '0; dsec_q <= '0; rv_q <= 1'b0;
    end else if (en) begin
      wsec_q <= wsec_d; rsec_q <= rsec_d; dsec_q <= dsec_d; rv_q <= rv_d;
    end
  end
endmodule

// File: rtl/fifo_bist.sv
`timescale 1ns/1ps
module fifo_bist import fbist_pkg::*; #(
  parameter int AW   = 5,
  parameter int DW   = 8,
  parameter int NCFG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_shift_en,
  input  logic          ctl_sdi,
  input  logic          ctl_update,
  input  logic          sig_shift_en,
  output logic          sig_sdo,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata
);
  logic [CTL_W-1:0]   ctl_word;
  logic [3*CRC_W-1:0] sig_chain;
  logic [AW-1:0]      wptr, rptr;
  logic [AW:0]        occ, depth;
  logic               start_acc, run, flush, full, empty;

  assign start_acc = ctl_update && ctl_word[2] && !busy;

  fbist_ctl #(.W(CTL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .shift_en(ctl_shift_en), .sdi(ctl_sdi), .word(ctl_word)
  );

  fbist_seq #(.AW(AW), .DW(DW), .NCFG(NCFG)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_acc),
    .sel_in(ctl_word[1:0]), .casc_in(ctl_word[3]),
    .busy(busy), .run(run), .flush(flush), .we(mem_we), .re(mem_re),
    .waddr(mem_waddr), .raddr(mem_raddr), .wdata(mem_wdata),
    .full(full), .empty(empty), .wptr(wptr), .rptr(rptr), .occ(occ), .depth(depth)
  );

  fbist_sig #(.AW(AW), .DW(DW)) u_sig (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .run(run), .flush(flush),
    .shift(sig_shift_en && !busy), .full(full), .empty(empty),
    .we(mem_we), .re(mem_re), .wptr(wptr), .rptr(rptr), .rdata(mem_rdata),
    .sdo(sig_sdo), .chain(sig_chain)
  );
endmodule

// File: rtl/fbist_chk.sv
`timescale 1ns/1ps
module fbist_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          ctl_update,
  input logic [7:0]    ctl_word,
  input logic          sig_shift_en,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_waddr,
  input logic [AW-1:0] mem_raddr,
  input logic [AW:0]   occ,
  input logic [AW:0]   depth,
  input logic [47:0]   sig_chain
);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_update && ctl_word[2]) |=> busy);

  p_idle_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_update && !ctl_word[2]) |=> !busy);

  p_waddr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({1'b0, mem_waddr} < depth));

  p_raddr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> ({1'b0, mem_raddr} < depth));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (occ < depth));

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (occ != '0));

  p_sig_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sig_shift_en && !ctl_update) |=> $stable(sig_chain));
endmodule

bind fifo_bist fbist_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ctl_update(ctl_update),
  .ctl_word(ctl_word), .sig_shift_en(sig_shift_en), .mem_we(mem_we),
  .mem_re(mem_re), .mem_waddr(mem_waddr), .mem_raddr(mem_raddr),
  .occ(occ), .depth(depth), .sig_chain(sig_chain)
);

// File: tb/sim_fifo_bist.sv
`timescale 1ns/1ps
module sim_fifo_bist;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int NCFG = 4;
  localparam int TOPD = 1 << AW;
  localparam int RUN_LEN = 121;

  logic clk, rst_n, ctl_shift_en, ctl_sdi, ctl_update, sig_shift_en;
  logic sig_sdo, busy, mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  fifo_bist #(.AW(AW), .DW(DW), .NCFG(NCFG)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_shift_en(ctl_shift_en), .ctl_sdi(ctl_sdi),
    .ctl_update(ctl_update), .sig_shift_en(sig_shift_en), .sig_sdo(sig_sdo),
    .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  // RAM array: registered read, old data on same-cycle write
  logic [DW-1:0] ram [TOPD];
  initial begin
    for (int i = 0; i < TOPD; i++) ram[i] = '0;
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= ram[mem_raddr];
    if (mem_we) ram[mem_waddr] <= mem_wdata;
  end

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_tests, n_fail, cyc;
  bit live;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st, m_cfg, m_step, m_sel, m_wp, m_rp, m_cnt;
  bit m_casc, m_rv;
  bit [7:0] m_rd, m_ctl;
  bit [15:0] ca, cb, cc;
  bit [7:0] m_mem [TOPD];

  function automatic bit [15:0] crc_upd(bit [15:0] c, int d, int n);
    for (int i = n - 1; i >= 0; i--) begin
      bit fb;
      fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic int m_depth();
    return TOPD >> m_cfg;
  endfunction

  function automatic bit m_ww();
    int d = m_depth();
    case (m_sel)
      0: return m_step < d;
      1: return (m_step % 2) == 0;
      2: return 1'b1;
      default: return m_step >= d;
    endcase
  endfunction

  function automatic bit m_wr();
    int d = m_depth();
    case (m_sel)
      0: return m_step >= d;
      1: return (m_step % 2) == 1;
      2: return m_step != 0;
      default: return m_step < d;
    endcase
  endfunction

  function automatic bit e_we();
    return (m_st == 1) && m_ww() && (m_cnt < m_depth());
  endfunction
  function automatic bit e_re();
    return (m_st == 1) && m_wr() && (m_cnt > 0);
  endfunction
  function automatic bit [7:0] e_wdata();
    bit [7:0] v = 8'(m_wp);
    return (m_cfg % 2 == 1) ? ~v : v;
  endfunction

  initial begin
    m_st = 0; m_cfg = 0; m_step = 0; m_sel = 0; m_wp = 0; m_rp = 0; m_cnt = 0;
    m_casc = 0; m_rv = 0; m_rd = 0; m_ctl = 0; ca = 0; cb = 0; cc = 0;
    for (int i = 0; i < TOPD; i++) m_mem[i] = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ctl = 0; ca = 0; cb = 0; cc = 0; m_rv = 0;
      m_cfg = 0; m_step = 0; m_wp = 0; m_rp = 0; m_cnt = 0; m_sel = 0; m_casc = 0;
    end else begin
      if (m_st == 0) begin
        if (ctl_update && m_ctl[2]) begin
          m_st = 1; m_cfg = 0; m_step = 0; m_wp = 0; m_rp = 0; m_cnt = 0;
          m_sel = int'(m_ctl[1:0]); m_casc = m_ctl[3];
          ca = 16'hFFFF; cb = 16'hFFFF; cc = 16'hFFFF; m_rv = 0;
        end else if (sig_shift_en) begin
          bit [47:0] t;
          t = {ca, cb, cc} >> 1;
          {ca, cb, cc} = t;
        end
      end else if (m_st == 1) begin
        int d, av, bv;
        bit w, r, fl, em;
        d = m_depth();
        fl = m_cnt >= d; em = m_cnt == 0;
        w = e_we(); r = e_re();
        av = (fl ? 128 : 0) + (em ? 64 : 0) + (w ? 32 : 0) + m_wp;
        bv = (r ? 32 : 0) + m_rp;
        ca = crc_upd(ca, av, AW + 3);
        cb = crc_upd(cb, bv, AW + 1);
        if (m_rv) cc = crc_upd(cc, int'(m_rd), DW);
        if (r) m_rd = m_mem[m_rp % d];
        m_rv = r;
        if (w) m_mem[m_wp % d] = e_wdata();
        m_wp = (m_wp + (w ? 1 : 0)) % TOPD;
        m_rp = (m_rp + (r ? 1 : 0)) % TOPD;
        m_cnt = m_cnt + (w ? 1 : 0) - (r ? 1 : 0);
        if (m_step == 2 * d - 1) begin
          m_step = 0;
          if (m_cfg == NCFG - 1) m_st = 2;
          else begin
            m_cfg++;
            if (!m_casc) begin m_wp = 0; m_rp = 0; m_cnt = 0; end
          end
        end else m_step++;
      end else begin
        if (m_rv) cc = crc_upd(cc, int'(m_rd), DW);
        m_rv = 0; m_st = 0;
      end
      if (ctl_shift_en) m_ctl = {ctl_sdi, m_ctl[7:1]};
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (live && rst_n) begin
      bit ok;
      ok = (busy == (m_st != 0)) && (mem_we == e_we()) && (mem_re == e_re())
           && (sig_sdo == cc[0]);
      check(ok, "R3/R5 cycle: busy,we,re,sdo", {busy, mem_we, mem_re, sig_sdo},
            {(m_st != 0), e_we(), e_re(), cc[0]});
      if (mem_we && e_we()) begin
        check(int'(mem_waddr) == m_wp % m_depth(), "R4 write address", mem_waddr, m_wp % m_depth());
        check(mem_wdata == e_wdata(), "R8 write data", mem_wdata, e_wdata());
      end
      if (mem_re && e_re())
        check(int'(mem_raddr) == m_rp % m_depth(), "R4 read address", mem_raddr, m_rp % m_depth());
    end
  end

  // ---------------- stimulus ----------------
  task automatic load_word(bit [7:0] w);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ctl_shift_en = 1'b1; ctl_sdi = w[i];
    end
    @(negedge clk); ctl_shift_en = 1'b0; ctl_sdi = 1'b0;
  endtask

  task automatic pulse_update();
    ctl_update = 1'b1;
    @(negedge clk); ctl_update = 1'b0;
  endtask

  task automatic read_sig(output bit [47:0] got);
    for (int i = 0; i < 48; i++) begin
      got[i] = sig_sdo;
      sig_shift_en = 1'b1;
      @(negedge clk);
    end
    sig_shift_en = 1'b0;
  endtask

  task automatic run_one(bit [7:0] w, bit poke_upd, bit poke_shift, string tag);
    int n;
    bit [47:0] exp, got;
    load_word(w);
    pulse_update();
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (poke_upd && n == 10) ctl_update = 1'b1;
      if (poke_upd && n == 11) ctl_update = 1'b0;
      if (poke_shift) sig_shift_en = (n >= 20 && n < 30);
      @(negedge clk);
    end
    ctl_update = 1'b0; sig_shift_en = 1'b0;
    check(n == RUN_LEN, {tag, " R4 busy length"}, n, RUN_LEN);
    exp = {ca, cb, cc};
    read_sig(got);
    check(got == exp, {tag, " R9 signature"}, got, exp);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; live = 0;
    rst_n = 1'b0; ctl_shift_en = 0; ctl_sdi = 0; ctl_update = 0; sig_shift_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; live = 1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(!mem_we && !mem_re, "R1 no RAM access", {mem_we, mem_re}, 0);
    begin
      bit [47:0] g;
      read_sig(g);
      check(g == 48'h0, "R1 signature zero", g, 0);
    end
    // R3: start bit clear -> no run
    load_word(8'h01);
    pulse_update();
    check(busy == 1'b0, "R3 update without start", busy, 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R3 still idle", busy, 0);
    // R5/R7: all tests, cascade off and on
    for (int s = 0; s < 4; s++) begin
      run_one(8'(4 + s), 0, 0, "R5 casc0");
      run_one(8'(12 + s), 0, 0, "R7 casc1");
    end
    // R2: reserved bits ignored
    run_one(8'hF6, 0, 0, "R2 reserved set");
    // R3: update during busy ignored; R10: shift during busy ignored
    run_one(8'h07, 1, 0, "R3 update while busy");
    run_one(8'h0D, 0, 1, "R10 shift while busy");
    // R10: signature holds with no shift
    begin
      bit [47:0] e2, g2;
      run_one(8'h06, 0, 0, "R10 base");
      load_word(8'h05);
      pulse_update();
      repeat (130) @(negedge clk);
      e2 = {ca, cb, cc};
      repeat (5) @(negedge clk);
      read_sig(g2);
      check(g2 == e2, "R10 hold without shift", g2, e2);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog R4 actual=%0d expected<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end
endmodule